// File: doc/BRIEF.md
# Configurable Reset Sequencer

The block gathers every reset request of a small microcontroller into a single reset for the core, then keeps that reset asserted for a start-up interval before letting the core run. Four requests are served: power-on, the external reset pin, the low-supply detector and the watchdog. They are combined by OR and brought into the oscillator clock domain through a two-stage synchronizer. Once the synchronized request falls, a counter runs for the start-up interval, and the core reset falls one cycle after the counter reaches its terminal value.

When a reset is entered, the block captures a 16-bit configuration word from a fixed, non-addressed storage port and holds it until the next reset entry. Three fields of that word steer the sequencer itself. One decides whether the low-supply request is honoured. One selects a short or a long start-up interval. One decides whether the watchdog comes out of reset already enabled. The block also reports which source caused the last reset, and it flags configuration words whose reserved bits are not zero.

Top module: `rstseq_top`

## Requirements
- R1: While any of por_i, pin_rst_i or wdg_rst_i is high, core_rst_o is high from the third rising edge onward and stays high for as long as the request is held.
- R2: lvd_i requests a reset only when bit 8 of the latched word is 1. When that bit is 0, lvd_i has no effect on core_rst_o or cause_o.
- R3: Let the last active request be seen low at rising edge S. core_rst_o then falls at edge S+1+N, which is N+2 edges counted from S inclusive. N is 2048 when bit 2 of the latched word is 0 and 32768 when it is 1.
- R4: A request that reappears while the start-up interval is running restarts the whole interval, measured from the new release.
- R5: opt_word_i is captured on entry into reset (continuously while por_i is high, and at the first synchronized edge of any other request). opt_q_o keeps the captured value afterwards, and later changes on opt_word_i have no effect on it.
- R6: wdg_en_o is 0 while core_rst_o is high. At the edge where core_rst_o falls, it takes the value of bit 3 of the latched word.
- R7: cfg_err_o is 1 exactly when any of bits 15, 14, 13, 11 or 10 of the latched word is 1.
- R8: cause_o is latched together with the word, with the codes 0 for power-on, 1 for pin, 2 for low supply and 3 for watchdog. When requests arrive together, the priority is power-on, then pin, then low supply, then watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on reset request, active high; also the synchronous reset of the block |
| pin_rst_i | input | 1 | External reset pin request, active high |
| lvd_i | input | 1 | Low-supply detector request, active high |
| wdg_rst_i | input | 1 | Watchdog timeout request, active high |
| opt_word_i | input | 16 | Configuration word from the non-user storage |
| core_rst_o | output | 1 | Reset to the core, active high |
| opt_q_o | output | 16 | Latched configuration word |
| wdg_en_o | output | 1 | Watchdog enabled by hardware after reset |
| cause_o | output | 2 | Source of the last reset |
| cfg_err_o | output | 1 | Reserved bits of the latched word are not zero |

## Verification
A wrong counter state shows on only one port, core_rst_o, and only at the moment of release: an early or late release by even one cycle changes the measured latency, so every release is timed exactly against N+2. A stale or missed capture does not show in the reset itself. It shows in opt_q_o, cause_o and cfg_err_o on the first sample after release, and it shows in the next release latency when the delay bit differs. A masking error on the low-supply request shows at once as a spurious core reset, within three edges of lvd_i rising.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int OPT_W        = 16;
  localparam int BIT_LONG_DLY = 2;
  localparam int BIT_WDG_HW   = 3;
  localparam int BIT_LVD_EN   = 8;
  // reserved positions 15..13 and 11..10
  localparam logic [OPT_W-1:0] RSV_MASK = 16'hEC00;

  localparam int NSRC    = 4;
  localparam int SRC_POR = 0;
  localparam int SRC_PIN = 1;
  localparam int SRC_LVD = 2;
  localparam int SRC_WDG = 3;

  typedef enum logic [1:0] {
    CAUSE_POR = 2'd0,
    CAUSE_PIN = 2'd1,
    CAUSE_LVD = 2'd2,
    CAUSE_WDG = 2'd3
  } cause_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) stg[g] <= stg[g-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rstseq_optlatch.sv
module rstseq_optlatch
  import rstseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_sync,
  input  logic [NSRC-1:0]  src_sync,
  input  logic [OPT_W-1:0] word_i,
  output logic [OPT_W-1:0] opt_q,
  output cause_e           cause_q,
  output logic             err_q
);
  logic rst_d;

  function automatic cause_e pick(input logic [NSRC-1:0] s);
    if (s[SRC_POR])      return CAUSE_POR;
    else if (s[SRC_PIN]) return CAUSE_PIN;
    else if (s[SRC_LVD]) return CAUSE_LVD;
    else                 return CAUSE_WDG;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q   <= word_i;
      cause_q <= CAUSE_POR;
      err_q   <= |(word_i & RSV_MASK);
      rst_d   <= 1'b0;
    end else begin
      rst_d <= rst_sync;
      if (rst_sync && !rst_d) begin
        opt_q   <= word_i;
        cause_q <= pick(src_sync);
        err_q   <= |(word_i & RSV_MASK);
      end
    end
  end

  AST_POR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rst_sync && !rst_d && src_sync[SRC_POR]) |=> (cause_q == CAUSE_POR)); // R8
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
  parameter int SHORT_DLY = 2048,
  parameter int LONG_DLY  = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_sync,
  input  logic long_sel,
  input  logic wdg_hw,
  output logic core_rst_o,
  output logic wdg_en_o
);
  localparam int MAXD = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;
  localparam logic [CW-1:0] TERM_S = CW'(SHORT_DLY - 1);
  localparam logic [CW-1:0] TERM_L = CW'(LONG_DLY - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] term;

  assign term = long_sel ? TERM_L : TERM_S;

  always_ff @(posedge clk) begin
    if (rst || rst_sync) begin
      core_rst_o <= 1'b1;
      cnt        <= '0;
      wdg_en_o   <= 1'b0;
    end else if (core_rst_o) begin
      if (cnt == term) begin
        core_rst_o <= 1'b0;
        wdg_en_o   <= wdg_hw;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rst_sync |=> core_rst_o); // R1
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    rst_sync |=> (cnt == '0)); // R4
  AST_EXACT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> ($past(cnt) == $past(term))); // R3
  AST_WDG_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(wdg_en_o) |-> $fell(core_rst_o)); // R6
  AST_WDG_LOW_IN_RST: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |-> !wdg_en_o); // R6
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int SHORT_DLY  = 2048,
  parameter int LONG_DLY   = 32768,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             pin_rst_i,
  input  logic             lvd_i,
  input  logic             wdg_rst_i,
  input  logic [OPT_W-1:0] opt_word_i,
  output logic             core_rst_o,
  output logic [OPT_W-1:0] opt_q_o,
  output logic             wdg_en_o,
  output logic [1:0]       cause_o,
  output logic             cfg_err_o
);
  logic [NSRC-1:0] src_raw;
  logic [NSRC-1:0] src_sync;
  logic            rst_sync;
  cause_e          cause_q;

  assign src_raw[SRC_POR] = por_i;
  assign src_raw[SRC_PIN] = pin_rst_i;
  assign src_raw[SRC_LVD] = lvd_i & opt_q_o[BIT_LVD_EN];
  assign src_raw[SRC_WDG] = wdg_rst_i;

  rstseq_sync #(.W(NSRC), .STAGES(SYNC_STAGE)) u_sync (
    .clk (clk_i),
    .d   (src_raw),
    .q   (src_sync)
  );

  assign rst_sync = |src_sync;

  rstseq_optlatch u_latch (
    .clk      (clk_i),
    .rst      (por_i),
    .rst_sync (rst_sync),
    .src_sync (src_sync),
    .word_i   (opt_word_i),
    .opt_q    (opt_q_o),
    .cause_q  (cause_q),
    .err_q    (cfg_err_o)
  );

  assign cause_o = cause_q;

  rstseq_delay #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_delay (
    .clk        (clk_i),
    .rst        (por_i),
    .rst_sync   (rst_sync),
    .long_sel   (opt_q_o[BIT_LONG_DLY]),
    .wdg_hw     (opt_q_o[BIT_WDG_HW]),
    .core_rst_o (core_rst_o),
    .wdg_en_o   (wdg_en_o)
  );

  AST_OPT_HELD: assert property (@(posedge clk_i) disable iff (por_i)
    (!core_rst_o && !rst_sync) |=> $stable(opt_q_o)); // R5
  AST_ERR_MATCH: assert property (@(posedge clk_i) disable iff (por_i)
    cfg_err_o == |(opt_q_o & RSV_MASK)); // R7
  AST_LVD_MASKED: assert property (@(posedge clk_i) disable iff (por_i)
    (!opt_q_o[BIT_LVD_EN] && !rst_sync && !core_rst_o && !pin_rst_i && !wdg_rst_i
     && !$past(pin_rst_i) && !$past(wdg_rst_i) && !$past(opt_q_o[BIT_LVD_EN]))
    |=> !src_sync[SRC_LVD]); // R2
endmodule

// File: tb/tb_rstseq_top.sv
module tb_rstseq_top;
  import rstseq_pkg::*;

  logic        clk_i = 1'b0;
  logic        por_i, pin_rst_i, lvd_i, wdg_rst_i;
  logic [15:0] opt_word_i;
  logic        core_rst_o, wdg_en_o, cfg_err_o;
  logic [15:0] opt_q_o;
  logic [1:0]  cause_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  rstseq_top dut (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .pin_rst_i  (pin_rst_i),
    .lvd_i      (lvd_i),
    .wdg_rst_i  (wdg_rst_i),
    .opt_word_i (opt_word_i),
    .core_rst_o (core_rst_o),
    .opt_q_o    (opt_q_o),
    .wdg_en_o   (wdg_en_o),
    .cause_o    (cause_o),
    .cfg_err_o  (cfg_err_o)
  );

  // fields: [23:22] source (0 por,1 pin,2 lvd,3 wdg), [21:20] cause,
  // [19] cfg error, [18] watchdog enable, [15:0] option word
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 1'b0, 2'b00, 16'h0000},
    {2'd1, 2'd1, 1'b0, 1'b1, 2'b00, 16'h0108},
    {2'd2, 2'd2, 1'b0, 1'b0, 2'b00, 16'h0100},
    {2'd3, 2'd3, 1'b1, 1'b1, 2'b00, 16'h2008},
    {2'd1, 2'd1, 1'b1, 1'b0, 2'b00, 16'h0404},
    {2'd1, 2'd1, 1'b0, 1'b0, 2'b00, 16'h1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] m);
    por_i     = m[0];
    pin_rst_i = m[1];
    lvd_i     = m[2];
    wdg_rst_i = m[3];
  endtask

  task automatic apply(input logic [3:0] m, input int hold);
    drive(m);
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk_i);
      if (i == 3) begin
        chk("R1 core reset while request held", core_rst_o, 1);
        chk("R6 watchdog flag low in reset", wdg_en_o, 0);
      end
    end
    drive(4'b0000);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (core_rst_o && n < 40000);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] w;
    drive(4'b0001);
    opt_word_i = 16'h0000;

    for (int v = 0; v < NV; v++) begin
      w = VEC[v][15:0];
      opt_word_i = w;
      apply(4'(1 << VEC[v][23:22]), 5);
      measure(n);
      chk("R3 release latency", n, w[2] ? 32770 : 2050);
      chk("R8 cause code", cause_o, VEC[v][21:20]);
      chk("R7 reserved bit flag", cfg_err_o, VEC[v][19]);
      chk("R6 watchdog flag after release", wdg_en_o, VEC[v][18]);
      chk("R5 latched word", opt_q_o, w);
    end

    // R2: low-supply request masked (latched word 1000, bit 8 clear)
    lvd_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      chk("R2 masked lvd leaves core running", core_rst_o, 0);
    end
    lvd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R2 masked lvd leaves cause", cause_o, 2'd1);

    // R5: word changes outside reset are ignored
    opt_word_i = 16'hFFFF;
    repeat (20) @(negedge clk_i);
    chk("R5 word held after input change", opt_q_o, 16'h1000);
    chk("R5 error flag held", cfg_err_o, 0);

    // R4: request during start-up interval restarts it
    opt_word_i = 16'h0000;
    apply(4'b0010, 5);
    repeat (1000) @(negedge clk_i);
    chk("R4 still in reset mid-interval", core_rst_o, 1);
    apply(4'b0010, 1);
    measure(n);
    chk("R4 full interval after restart", n, 2050);

    // R8: priority among simultaneous requests
    apply(4'b1010, 5);
    measure(n);
    chk("R8 pin beats watchdog", cause_o, 2'd1);
    apply(4'b1111, 5);
    measure(n);
    chk("R8 power-on beats all", cause_o, 2'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule